// File: doc/BRIEF.md
# Programmable Async-Map Octet Stuffer

This block escapes a byte stream for HDLC-like framing. It sits after the frame check sequence has been appended and after any partial scrambling, and before the final scrambler. A data byte is escaped when it equals the flag value, the escape value, or an enabled entry of a small programmable character map. Such a byte leaves as two bytes: the escape value, then the original byte XORed with a masking value.

Bytes tagged as frame delimiters bypass the escape check, so the opening and closing flags reach the line unchanged. Both sides are valid/ready byte streams. Each byte carries a delimiter tag that tells a framing flag apart from payload. The output is registered. When a byte is escaped, the input is held off for one cycle while the second byte of the pair drains.

The flag, escape and mask values are configuration inputs. So are the map entries and their enables. They are expected to stay stable while a frame is in flight.

Top module: `octet_escaper`

## Requirements
- R1: A data byte that needs no escaping leaves as one output byte equal to the input, with out_delim low. A byte accepted at clock edge k is presented on the output after edge k.
- R2: A data byte (in_delim low) equal to cfg_flag or cfg_esc leaves as two bytes: cfg_esc, then the byte XOR cfg_mask. This holds whatever the map holds, including a fully disabled map.
- R3: Map entry i is cfg_map_val[8*i+7:8*i] and is enabled by cfg_map_en[i]. A data byte equal to an enabled entry is escaped in the same two-byte form as R2.
- R4: A map entry whose enable bit is low has no effect. A data byte equal only to that entry passes as one unchanged byte.
- R5: A byte with in_delim high is never escaped. It leaves as one unchanged byte with out_delim high. Both bytes of an escape pair carry out_delim low.
- R6: After an escaped byte is accepted, in_ready is low for exactly the one cycle in which the second byte of the pair waits. This holds when out_ready stays high.
- R7: While reset is asserted and right after it, out_valid is low and in_ready is high.
- R8: While out_valid is high and out_ready is low, out_data and out_delim hold steady. Over any pattern of backpressure, the output sequence is the exact escaped form of the input sequence, with no byte lost, repeated or reordered.
- R9: The escape and mask values are programmable. After cfg_esc and cfg_mask are changed, escape pairs use the new values, and a byte equal to the new escape value is escaped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_flag | input | 8 | Flag value, escaped when it appears as data |
| cfg_esc | input | 8 | Escape value, first byte of each pair |
| cfg_mask | input | 8 | XOR mask applied to the escaped byte |
| cfg_map_val | input | 8*MAP_N | Character map entries, entry i in bits 8i+7..8i |
| cfg_map_en | input | MAP_N | Per-entry enable of the character map |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_delim | input | 1 | Input byte is a frame delimiter |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_delim | output | 1 | Output byte is a frame delimiter |

## Verification
Two events can meet in one cycle. The second byte of an escape pair moves into the output register, and downstream withdraws out_ready or a new input byte is waiting. Either can coincide with the refill of the output register. A pseudo-random out_ready pattern provokes this while a table of flags, escape values, enabled and disabled map entries and delimiters is streamed through. The whole captured output is then compared byte for byte, tag included, against an expansion the bench computes itself. Directed cases pin down the exact cycle of the one-cycle stall and check that the held output stays frozen under a long stall.

// File: rtl/esc_pkg.sv
`timescale 1ns/1ps
package esc_pkg;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic  delim;
    byte_t data;
  } beat_t;

  function automatic byte_t esc_masked(byte_t d, byte_t m);
    return d ^ m;
  endfunction

  function automatic logic esc_special(byte_t d, byte_t flag, byte_t esc);
    return (d == flag) || (d == esc);
  endfunction
endpackage

// File: rtl/esc_match.sv
`timescale 1ns/1ps
module esc_match
  import esc_pkg::*;
#(
  parameter int MAP_N = 5
) (
  input  logic [BYTE_W-1:0]       data,
  input  logic                    delim,
  input  logic [BYTE_W-1:0]       cfg_flag,
  input  logic [BYTE_W-1:0]       cfg_esc,
  input  logic [MAP_N*BYTE_W-1:0] cfg_map_val,
  input  logic [MAP_N-1:0]        cfg_map_en,
  output logic                    need_esc
);
  logic [MAP_N-1:0] ent_hit;
  logic             map_hit;
  logic             fixed_hit;

  for (genvar gi = 0; gi < MAP_N; gi++) begin : g_ent
    assign ent_hit[gi] = cfg_map_en[gi] &&
                         (cfg_map_val[gi*BYTE_W +: BYTE_W] == data);
  end

  assign map_hit   = |ent_hit;
  assign fixed_hit = esc_special(data, cfg_flag, cfg_esc);
  assign need_esc  = !delim && (map_hit || fixed_hit);
endmodule

// File: rtl/esc_pipe.sv
`timescale 1ns/1ps
module esc_pipe
  import esc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_delim,
  input  logic              need_esc,
  input  logic [BYTE_W-1:0] cfg_esc,
  input  logic [BYTE_W-1:0] cfg_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_delim
);
  logic  out_v_q;
  beat_t out_q;
  logic  pend_q;
  byte_t pend_d_q;

  logic slot_free;
  logic in_fire;
  logic esc_fire;
  logic pend_fire;

  assign slot_free = !out_v_q || out_ready;
  assign in_ready  = slot_free && !pend_q;
  assign in_fire   = in_valid && in_ready;
  assign esc_fire  = in_fire && need_esc;
  assign pend_fire = pend_q && slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v_q  <= 1'b0;
      out_q    <= '0;
      pend_q   <= 1'b0;
      pend_d_q <= '0;
    end else if (pend_fire) begin
      out_v_q  <= 1'b1;
      out_q    <= '{delim: 1'b0, data: pend_d_q};
      pend_q   <= 1'b0;
    end else if (in_fire) begin
      out_v_q <= 1'b1;
      if (need_esc) begin
        out_q    <= '{delim: 1'b0, data: cfg_esc};
        pend_q   <= 1'b1;
        pend_d_q <= esc_masked(in_data, cfg_mask);
      end else begin
        out_q <= '{delim: in_delim, data: in_data};
      end
    end else if (out_ready) begin
      out_v_q <= 1'b0;
    end
  end

  assign out_valid = out_v_q;
  assign out_data  = out_q.data;
  assign out_delim = out_q.delim;

  // R8: held output stays frozen under backpressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_delim)));

  // R6: one-cycle input stall after an escape is accepted
  a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
    esc_fire |=> !in_ready);

  // R2: first byte of a pair is the escape value
  a_r2_pair_head: assert property (@(posedge clk) disable iff (!rst_n)
    esc_fire |=> (out_valid && out_data == $past(cfg_esc) && !out_delim));

  // R5: delimiter bytes pass raw and keep their tag
  a_r5_delim_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_delim) |=>
      (out_valid && out_delim && out_data == $past(in_data)));

  // R1: accepted plain byte is presented on the next cycle
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !need_esc && !in_delim) |=>
      (out_valid && !out_delim && out_data == $past(in_data)));
endmodule

// File: rtl/octet_escaper.sv
`timescale 1ns/1ps
module octet_escaper
  import esc_pkg::*;
#(
  parameter int MAP_N = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              cfg_flag,
  input  logic [7:0]              cfg_esc,
  input  logic [7:0]              cfg_mask,
  input  logic [MAP_N*8-1:0]      cfg_map_val,
  input  logic [MAP_N-1:0]        cfg_map_en,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [7:0]              in_data,
  input  logic                    in_delim,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data,
  output logic                    out_delim
);
  logic need_esc;

  esc_match #(.MAP_N(MAP_N)) i_match (
    .data        (in_data),
    .delim       (in_delim),
    .cfg_flag    (cfg_flag),
    .cfg_esc     (cfg_esc),
    .cfg_map_val (cfg_map_val),
    .cfg_map_en  (cfg_map_en),
    .need_esc    (need_esc)
  );

  esc_pipe i_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_delim  (in_delim),
    .need_esc  (need_esc),
    .cfg_esc   (cfg_esc),
    .cfg_mask  (cfg_mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_delim (out_delim)
  );

  // R7: idle output and open input right after reset
  a_r7_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

// File: tb/test_octet_escaper.sv
`timescale 1ns/1ps
module test_octet_escaper;
  localparam int MAP_N = 5;
  localparam int NV    = 16;
  // {expected output length, delimiter tag, byte}
  localparam logic [10:0] TBL [NV] = '{
    {2'd1, 1'b1, 8'h7E}, {2'd1, 1'b0, 8'h41}, {2'd2, 1'b0, 8'h7E},
    {2'd2, 1'b0, 8'h7D}, {2'd2, 1'b0, 8'h11}, {2'd2, 1'b0, 8'h13},
    {2'd2, 1'b0, 8'h03}, {2'd1, 1'b0, 8'hFF}, {2'd2, 1'b0, 8'h00},
    {2'd1, 1'b0, 8'h5E}, {2'd1, 1'b0, 8'h12}, {2'd1, 1'b1, 8'h7E},
    {2'd1, 1'b1, 8'h7D},
    {2'd2, 1'b0, 8'h55}, {2'd1, 1'b0, 8'h11}, {2'd2, 1'b0, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cfg_flag, cfg_esc, cfg_mask;
  logic [MAP_N*8-1:0] cfg_map_val;
  logic [MAP_N-1:0] cfg_map_en;
  logic in_valid, in_ready, in_delim;
  logic [7:0] in_data;
  logic out_valid, out_ready, out_delim;
  logic [7:0] out_data;
  logic [7:0] lfsr;
  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  octet_escaper #(.MAP_N(MAP_N)) i_octet_escaper (
    .clk(clk), .rst_n(rst_n), .cfg_flag(cfg_flag), .cfg_esc(cfg_esc),
    .cfg_mask(cfg_mask), .cfg_map_val(cfg_map_val), .cfg_map_en(cfg_map_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_delim(in_delim), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_delim(out_delim)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_map_hit(input logic [7:0] d, input bit only_en);
    for (int i = 0; i < MAP_N; i++)
      if ((cfg_map_val >> (8 * i)) % 256 == d && (!only_en || cfg_map_en[i]))
        return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ref_needs(input logic [7:0] d, input bit dl);
    if (dl) return 1'b0;
    return (d == cfg_flag) || (d == cfg_esc) || ref_map_hit(d, 1'b1);
  endfunction

  function automatic string req_of(input logic [7:0] d, input bit dl, input bit alt);
    if (dl) return "R5";
    if (alt) return "R9";
    if (d == cfg_flag || d == cfg_esc) return "R2";
    if (ref_map_hit(d, 1'b1)) return "R3";
    if (ref_map_hit(d, 1'b0)) return "R4";
    return "R1";
  endfunction

  task automatic run_range(input int lo, input int hi, input bit bp, input bit alt);
    logic [7:0] obs_d [0:63];
    logic       obs_t [0:63];
    logic [7:0] exp_d [0:63];
    logic       exp_t [0:63];
    string      exp_r [0:63];
    int idx = lo;
    int obs_n = 0;
    int exp_n = 0;
    int tbl_n = 0;
    int cyc = 0;
    for (int v = lo; v <= hi; v++) begin
      logic [7:0] d = TBL[v][7:0];
      bit dl = TBL[v][8];
      tbl_n += int'(TBL[v][10:9]);
      if (ref_needs(d, dl)) begin
        exp_d[exp_n] = cfg_esc; exp_t[exp_n] = 1'b0;
        exp_r[exp_n] = req_of(d, dl, alt); exp_n++;
        exp_d[exp_n] = d ^ cfg_mask; exp_t[exp_n] = 1'b0;
        exp_r[exp_n] = req_of(d, dl, alt); exp_n++;
      end else begin
        exp_d[exp_n] = d; exp_t[exp_n] = dl;
        exp_r[exp_n] = req_of(d, dl, alt); exp_n++;
      end
    end
    while ((idx <= hi || obs_n < exp_n) && cyc < 2000) begin
      @(negedge clk);
      in_valid = (idx <= hi);
      in_data  = (idx <= hi) ? TBL[idx][7:0] : 8'h00;
      in_delim = (idx <= hi) ? TBL[idx][8] : 1'b0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      if (out_valid && out_ready && obs_n < 64) begin
        obs_d[obs_n] = out_data; obs_t[obs_n] = out_delim; obs_n++;
      end
      if (in_valid && in_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    chk(obs_n == tbl_n, "R8", "output byte count", obs_n, tbl_n);
    for (int k = 0; k < exp_n && k < obs_n; k++) begin
      chk(obs_d[k] == exp_d[k], exp_r[k], "byte value", obs_d[k], exp_d[k]);
      chk(obs_t[k] == exp_t[k], exp_r[k], "delimiter tag", obs_t[k], exp_t[k]);
    end
  endtask

  initial begin
    #750000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_delim = 1'b0;
    out_ready = 1'b1; lfsr = 8'hA5;
    cfg_flag = 8'h7E; cfg_esc = 8'h7D; cfg_mask = 8'h20;
    cfg_map_val = {8'h00, 8'hFF, 8'h03, 8'h13, 8'h11};
    cfg_map_en  = 5'b10111;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R7", "out_valid in reset", out_valid, 0);
    chk(in_ready, "R7", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R7", "idle after reset", {out_valid, in_ready}, 1);

    // R1: one-cycle latency of a plain byte
    in_valid = 1'b1; in_data = 8'h41; in_delim = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == 8'h41, "R1", "latency", out_data, 8'h41);

    // R6: escape stalls the input exactly one cycle
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h11;
    @(negedge clk);
    in_data = 8'h42;
    chk(!in_ready, "R6", "in_ready during pair", in_ready, 0);
    chk(out_data == 8'h7D, "R6", "pair head", out_data, 8'h7D);
    @(negedge clk);
    chk(in_ready, "R6", "in_ready after pair", in_ready, 1);
    chk(out_data == 8'h31, "R6", "pair tail", out_data, 8'h31);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_data == 8'h42, "R6", "byte after pair", out_data, 8'h42);
    @(negedge clk);

    // R8: long stall freezes the output
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'h7E; in_delim = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == 8'h7D, "R8", "held head", out_data, 8'h7D);
    chk(!in_ready, "R8", "input closed while held", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_data == 8'h5E, "R8", "tail after release", out_data, 8'h5E);
    @(negedge clk);

    run_range(0, 12, 1'b0, 1'b0);
    run_range(0, 12, 1'b1, 1'b0);

    // R9: new escape and mask values, map switched off
    cfg_esc = 8'h55; cfg_mask = 8'h0F; cfg_map_en = '0;
    run_range(13, 15, 1'b1, 1'b0);
    run_range(13, 15, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule